// File: doc/BRIEF.md
# Paired-Command DRAM Access Sequencer

This block sits at the front of a memory controller for a DRAM in which every access is opened by two commands on consecutive clocks. A read or write request carries a bank, an upper address and a lower address. For each accepted request the sequencer puts an opening command on the command bus with the bank and upper address, and on the very next clock a column command with the lower address. A bank that has been opened closes by itself after a fixed row-cycle count, so the sequencer never issues a precharge. It only has to track, for each bank, how long that bank stays busy.

The sequencer also works out when read data is valid and when write data has to be driven. It produces a read-valid window and a write-enable window for the data path. It books these windows ahead of time, so that no two bursts ever share a clock. Refresh requests come in from an outside arbiter. A refresh goes out as a write-type opening command followed by a refresh command in the column slot, which turns the pending write into a refresh. The CAS latency, read burst length, row-cycle count and refresh recovery count are parameters.

Top module: `twostep_seq`

## Requirements
- R1: In the cycle after a read handshake (`req_valid` and `req_ready` high at a clock edge), `cmd` is 1 (open-for-read) with `cmd_bank`/`cmd_addr` equal to the request's bank and upper address. In the following cycle `cmd` is 3 (column) with the same bank and `cmd_addr` equal to the zero-extended lower address.
- R2: A write request produces `cmd` 2 (open-for-write) in the cycle after its handshake, then `cmd` 3 in the next cycle with `cmd_wbl` equal to the request's 2-bit burst code.
- R3: `rd_valid` is high for BL/2 consecutive clocks, starting CL clocks after the cycle that shows the column command of a read.
- R4: `wr_en` starts CL-1 clocks after the column command of a write and lasts 1, 2 or 4 clocks for burst codes 00, 01 and 10. Code 11 gives BL/2 clocks.
- R5: `bank_busy[b]` is high from the cycle that shows bank b's opening command. Two opening commands to the same bank are never closer than TRC clocks, and they are exactly TRC clocks apart when the requests arrive back to back.
- R6: At most one request is accepted every two clocks. `req_ready` and `ref_ready` are low while the column slot is being issued. Requests to different idle banks whose data windows do not collide are accepted every two clocks.
- R7: A request whose data window would share a clock with an already booked read or write window is held (`req_ready` low) until its window fits. `rd_valid` and `wr_en` are never high together.
- R8: When `ref_valid` is high, all banks are idle and no data window is booked or active, the refresh wins over a pending request. `cmd` shows 2 and then 4 (refresh) with bank 0 and address 0, and the write-enable window never opens. All banks then read busy, and the next opening command comes REFC clocks after the refresh's first command.
- R9: When no command is issued, `cmd` is 0 (deselect) and `cmd_bank`, `cmd_addr` and `cmd_wbl` are all zero.
- R10: After reset, `cmd` is 0, `bank_busy` is all zero, `rd_valid` and `wr_en` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BW | Target bank |
| req_upper | input | UA_W | Upper (row) address |
| req_lower | input | LA_W | Lower (column) address |
| req_wbl | input | 2 | Write burst code |
| ref_valid | input | 1 | Refresh request from the external arbiter |
| ref_ready | output | 1 | Refresh accepted at this edge |
| cmd | output | 3 | Command code: 0 deselect, 1 open-read, 2 open-write, 3 column, 4 refresh |
| cmd_bank | output | BW | Bank field of the command |
| cmd_addr | output | UA_W | Upper address on opening commands, lower address on column commands |
| cmd_wbl | output | 2 | Write burst code, sent with the column command |
| rd_valid | output | 1 | Read data is valid this clock |
| wr_en | output | 1 | Write data and strobe must be driven this clock |
| bank_busy | output | NBANK | Per-bank busy flags |

## Verification
The bench sends two reads to one bank back to back. A timer that is off by one shows up directly as a spacing other than TRC. It issues a long write and follows it at once with a read, and then does the reverse. A sequencer that ignored collisions would raise `rd_valid` and `wr_en` in the same clock, or accept the second request two clocks after the first instead of three. It raises a refresh and a read together: a wrong priority shows up as an opening read, and a refresh that did not cancel the write as a `wr_en` pulse. It also raises a refresh right behind a read, which exposes a sequencer that refreshes before the read burst has drained. Each of the four write burst codes is checked against its own `wr_en` length, which catches a wrong decode or a CAS-latency offset that is off by one.

// File: rtl/twostep_pkg.sv
// Shared command encoding for the paired-command sequencer.
// Assumes: a 3-bit command field on the memory command bus.
package twostep_pkg;
    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_OPEN_RD = 3'd1,
        CMD_OPEN_WR = 3'd2,
        CMD_COL     = 3'd3,
        CMD_RFSH    = 3'd4
    } cmd_e;

    typedef enum logic {
        ST_FIRST  = 1'b0,
        ST_SECOND = 1'b1
    } seq_st_e;
endpackage

// File: rtl/ts_bank_timer.sv
// Per-bank row-cycle timers. Opening a bank loads its counter with TRC-1;
// a refresh loads every counter with REFC-1. A bank is busy while its
// counter is nonzero. Assumes TRC >= 2 and REFC >= 2, and that the
// caller never opens a busy bank.
module ts_bank_timer #(
    parameter int NBANK = 4,
    parameter int BW    = 2,
    parameter int TRC   = 6,
    parameter int REFC  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic [BW-1:0]    open_bank,
    input  logic             ref_en,
    output logic [NBANK-1:0] busy
);
    localparam int TMAX = (TRC > REFC) ? TRC : REFC;
    localparam int CW   = $clog2(TMAX + 1);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [CW-1:0] cnt_q;

        // Load on open or refresh, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (ref_en)
                cnt_q <= CW'(REFC - 1);
            else if (open_en && (open_bank == BW'(g)))
                cnt_q <= CW'(TRC - 1);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end

        assign busy[g] = (cnt_q != '0);

        // R5: a bank is only opened once its timer has run out
        a_r5_open_idle_bank: assert property (@(posedge clk) disable iff (!rst_n)
            (open_en && (open_bank == BW'(g))) |-> (cnt_q == '0));

        // R8: refresh only starts with this bank idle
        a_r8_refresh_bank_idle: assert property (@(posedge clk) disable iff (!rst_n)
            ref_en |-> (cnt_q == '0));
    end
endmodule

// File: rtl/ts_data_window.sv
// Data-bus reservation pipes. Bit 0 of each pipe is the current clock;
// higher bits are future clocks. A probe describes the window the
// presented request would need; free says it clashes with nothing
// booked. Booking ORs the window in, already shifted by one clock.
// Assumes CL >= 1 and probe_len <= WMAX.
module ts_data_window #(
    parameter int CL   = 3,
    parameter int WMAX = 4,
    parameter int LW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          probe_wr,
    input  logic [LW-1:0] probe_len,
    input  logic          book_en,
    output logic          free,
    output logic          rd_now,
    output logic          wr_now,
    output logic          idle
);
    localparam int DEPTH = CL + 3 + WMAX;

    logic [DEPTH-1:0] rd_q, wr_q, want;
    int               start;

    // Build the mask of clocks (relative to now) the probed request needs.
    always_comb begin
        start = probe_wr ? (CL + 1) : (CL + 2);
        for (int i = 0; i < DEPTH; i++)
            want[i] = (i >= start) && (i < start + int'(probe_len));
    end

    assign free   = ((rd_q | wr_q) & want) == '0;
    assign rd_now = rd_q[0];
    assign wr_now = wr_q[0];
    assign idle   = (rd_q == '0) && (wr_q == '0);

    // Advance the pipes by one clock and add any new booking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
        end else begin
            rd_q <= (rd_q >> 1) | ((book_en && !probe_wr) ? (want >> 1) : '0);
            wr_q <= (wr_q >> 1) | ((book_en &&  probe_wr) ? (want >> 1) : '0);
        end
    end

    // R7: read and write windows never share a clock
    a_r7_no_bus_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_q[0] && wr_q[0]));

    // R7: a booking only lands on free clocks
    a_r7_book_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        book_en |-> free);
endmodule

// File: rtl/twostep_seq.sv
// Paired-command access sequencer. Accepts one read/write request per
// two clocks. It issues an opening command (bank + upper address) and then
// a column command (lower address, write burst code). Refresh is issued as
// open-for-write followed by refresh. Bank timers and data-window
// reservation decide acceptance. Assumes UA_W >= LA_W, NBANK a power of
// two, and BL even.
module twostep_seq
    import twostep_pkg::*;
#(
    parameter  int NBANK = 4,
    parameter  int UA_W  = 12,
    parameter  int LA_W  = 8,
    parameter  int CL    = 3,
    parameter  int BL    = 4,
    parameter  int TRC   = 6,
    parameter  int REFC  = 9,
    localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [BW-1:0]    req_bank,
    input  logic [UA_W-1:0]  req_upper,
    input  logic [LA_W-1:0]  req_lower,
    input  logic [1:0]       req_wbl,
    input  logic             ref_valid,
    output logic             ref_ready,
    output logic [2:0]       cmd,
    output logic [BW-1:0]    cmd_bank,
    output logic [UA_W-1:0]  cmd_addr,
    output logic [1:0]       cmd_wbl,
    output logic             rd_valid,
    output logic             wr_en,
    output logic [NBANK-1:0] bank_busy
);
    localparam int RCLK = BL / 2;
    localparam int WMAX = (RCLK > 4) ? RCLK : 4;
    localparam int LW   = $clog2(WMAX + 1);

    seq_st_e          state_q;
    cmd_e             cmd_q;
    logic [BW-1:0]    bank_q;
    logic [UA_W-1:0]  addr_q;
    logic [1:0]       wbl_q;
    logic [LA_W-1:0]  lower_q;
    logic [1:0]       lwbl_q;
    logic             is_ref_q;

    logic [LW-1:0]    wlen, probe_len;
    logic             slot_free, win_idle, take_ref, take_req, can_req;

    // Decode the write burst code into a window length in clocks.
    always_comb begin
        case (req_wbl)
            2'b00:   wlen = LW'(1);
            2'b01:   wlen = LW'(2);
            2'b10:   wlen = LW'(4);
            default: wlen = LW'(RCLK);
        endcase
    end

    assign probe_len = req_write ? wlen : LW'(RCLK);

    // Arbitration: refresh first, then a request that fits bank and bus.
    always_comb begin
        take_ref  = (state_q == ST_FIRST) && ref_valid && (bank_busy == '0) && win_idle;
        can_req   = (state_q == ST_FIRST) && !take_ref && !bank_busy[req_bank] && slot_free;
        take_req  = can_req && req_valid;
        req_ready = can_req;
        ref_ready = take_ref;
    end

    ts_bank_timer #(
        .NBANK(NBANK), .BW(BW), .TRC(TRC), .REFC(REFC)
    ) u_timer (
        .clk(clk), .rst_n(rst_n),
        .open_en(take_req), .open_bank(req_bank),
        .ref_en(take_ref), .busy(bank_busy)
    );

    ts_data_window #(
        .CL(CL), .WMAX(WMAX), .LW(LW)
    ) u_window (
        .clk(clk), .rst_n(rst_n),
        .probe_wr(req_write), .probe_len(probe_len),
        .book_en(take_req), .free(slot_free),
        .rd_now(rd_valid), .wr_now(wr_en), .idle(win_idle)
    );

    // Command bus: opening command, then column/refresh, else deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_FIRST;
            cmd_q    <= CMD_NOP;
            bank_q   <= '0;
            addr_q   <= '0;
            wbl_q    <= '0;
            lower_q  <= '0;
            lwbl_q   <= '0;
            is_ref_q <= 1'b0;
        end else if (state_q == ST_SECOND) begin
            cmd_q   <= is_ref_q ? CMD_RFSH : CMD_COL;
            addr_q  <= is_ref_q ? '0 : UA_W'(lower_q);
            wbl_q   <= is_ref_q ? 2'b00 : lwbl_q;
            state_q <= ST_FIRST;
        end else if (take_ref) begin
            cmd_q    <= CMD_OPEN_WR;
            bank_q   <= '0;
            addr_q   <= '0;
            wbl_q    <= '0;
            is_ref_q <= 1'b1;
            state_q  <= ST_SECOND;
        end else if (take_req) begin
            cmd_q    <= req_write ? CMD_OPEN_WR : CMD_OPEN_RD;
            bank_q   <= req_bank;
            addr_q   <= req_upper;
            wbl_q    <= '0;
            lower_q  <= req_lower;
            lwbl_q   <= req_write ? req_wbl : 2'b00;
            is_ref_q <= 1'b0;
            state_q  <= ST_SECOND;
        end else begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            addr_q <= '0;
            wbl_q  <= '0;
        end
    end

    assign cmd      = cmd_q;
    assign cmd_bank = bank_q;
    assign cmd_addr = addr_q;
    assign cmd_wbl  = wbl_q;

    // R1: an open-for-read is always followed by a column command
    a_r1_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_OPEN_RD) |=> (cmd_q == CMD_COL));

    // R1: the bank field is held across the command pair
    a_r1_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_q == CMD_OPEN_RD) || (cmd_q == CMD_OPEN_WR)) |=> $stable(cmd_bank));

    // R2: an open-for-write is followed by column or refresh
    a_r2_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_OPEN_WR) |=> ((cmd_q == CMD_COL) || (cmd_q == CMD_RFSH)));

    // R6: nothing is accepted while the column slot is issued
    a_r6_no_accept_in_second: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECOND) |-> (!req_ready && !ref_ready));

    // R8: refresh starts only with banks idle and the data bus quiet
    a_r8_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ready |-> ((bank_busy == '0) && !rd_valid && !wr_en));

    // R9: a deselect carries all-zero fields
    a_r9_nop_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_NOP) |-> ((cmd_bank == '0) && (cmd_addr == '0) && (cmd_wbl == '0)));
endmodule

// File: tb/sim_twostep_seq.sv
// Directed bench for twostep_seq: one task per scenario, each checking
// its own results against cycle-indexed logs of the outputs.
module sim_twostep_seq;
    localparam int NBANK = 4;
    localparam int UA_W  = 12;
    localparam int LA_W  = 8;
    localparam int CL    = 3;
    localparam int BL    = 4;
    localparam int TRC   = 6;
    localparam int REFC  = 9;
    localparam int RCLK  = BL / 2;
    localparam int LOGN  = 1024;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0, req_write = 1'b0, ref_valid = 1'b0;
    logic [1:0]       req_bank = '0;
    logic [UA_W-1:0]  req_upper = '0;
    logic [LA_W-1:0]  req_lower = '0;
    logic [1:0]       req_wbl = '0;
    logic             req_ready, ref_ready, rd_valid, wr_en;
    logic [2:0]       cmd;
    logic [1:0]       cmd_bank, cmd_wbl;
    logic [UA_W-1:0]  cmd_addr;
    logic [NBANK-1:0] bank_busy;

    int nchk = 0, nfail = 0, cyc = 0;

    int cmd_log [LOGN], bank_log [LOGN], addr_log [LOGN], wbl_log [LOGN];
    int rdv_log [LOGN], wen_log [LOGN], busy_log [LOGN];

    twostep_seq #(
        .NBANK(NBANK), .UA_W(UA_W), .LA_W(LA_W),
        .CL(CL), .BL(BL), .TRC(TRC), .REFC(REFC)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_upper(req_upper), .req_lower(req_lower),
        .req_wbl(req_wbl), .ref_valid(ref_valid), .ref_ready(ref_ready),
        .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_wbl(cmd_wbl),
        .rd_valid(rd_valid), .wr_en(wr_en), .bank_busy(bank_busy)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        cmd_log[cyc % LOGN]  = int'(cmd);
        bank_log[cyc % LOGN] = int'(cmd_bank);
        addr_log[cyc % LOGN] = int'(cmd_addr);
        wbl_log[cyc % LOGN]  = int'(cmd_wbl);
        rdv_log[cyc % LOGN]  = int'(rd_valid);
        wen_log[cyc % LOGN]  = int'(wr_en);
        busy_log[cyc % LOGN] = int'(bank_busy);
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            nfail++;
            $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Present a request, wait for acceptance, return the opening-command cycle.
    task automatic send(input bit wr, input int bank, input int up, input int lo,
                        input int code, output int acc);
        req_write = wr;
        req_bank  = 2'(bank);
        req_upper = UA_W'(up);
        req_lower = LA_W'(lo);
        req_wbl   = 2'(code);
        req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc + 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic int wclocks(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return RCLK;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        settle(4);
        rst_n = 1'b1;
        #1;
        chk("R10 cmd after reset", int'(cmd), 0);
        chk("R10 busy after reset", int'(bank_busy), 0);
        chk("R10 rd_valid after reset", int'(rd_valid), 0);
        chk("R10 wr_en after reset", int'(wr_en), 0);
        chk("R10 req_ready after reset", int'(req_ready), 1);
        settle(2);
    endtask

    task automatic t_read();
        int a;
        send(1'b0, 1, 'hABC, 'h5A, 0, a);
        settle(12);
        chk("R1 open-read code", cmd_log[a % LOGN], 1);
        chk("R1 open-read bank", bank_log[a % LOGN], 1);
        chk("R1 open-read upper", addr_log[a % LOGN], 'hABC);
        chk("R1 column code", cmd_log[(a + 1) % LOGN], 3);
        chk("R1 column bank", bank_log[(a + 1) % LOGN], 1);
        chk("R1 column lower", addr_log[(a + 1) % LOGN], 'h5A);
        chk("R9 deselect code", cmd_log[(a + 2) % LOGN], 0);
        chk("R9 deselect addr", addr_log[(a + 2) % LOGN], 0);
        chk("R9 deselect bank", bank_log[(a + 2) % LOGN], 0);
        chk("R5 busy from open", (busy_log[a % LOGN] >> 1) & 1, 1);
        for (int k = 0; k < CL + RCLK + 2; k++) begin
            chk("R3 read window", rdv_log[(a + 1 + k) % LOGN],
                ((k >= CL) && (k < CL + RCLK)) ? 1 : 0);
            chk("R3 no write on read", wen_log[(a + 1 + k) % LOGN], 0);
        end
    endtask

    task automatic t_write_codes();
        for (int code = 0; code < 4; code++) begin
            int a;
            int len;
            send(1'b1, code, 'h100 + code, 'h20 + code, code, a);
            settle(14);
            len = wclocks(code);
            chk("R2 open-write code", cmd_log[a % LOGN], 2);
            chk("R2 open-write upper", addr_log[a % LOGN], 'h100 + code);
            chk("R2 column code", cmd_log[(a + 1) % LOGN], 3);
            chk("R2 column lower", addr_log[(a + 1) % LOGN], 'h20 + code);
            chk("R2 burst code sent", wbl_log[(a + 1) % LOGN], code);
            for (int k = 0; k < CL + 6; k++)
                chk("R4 write window", wen_log[(a + 1 + k) % LOGN],
                    ((k >= CL - 1) && (k < CL - 1 + len)) ? 1 : 0);
        end
    endtask

    task automatic t_same_bank();
        int a1, a2;
        send(1'b0, 2, 'h011, 'h01, 0, a1);
        send(1'b0, 2, 'h022, 'h02, 0, a2);
        chk("R5 same-bank spacing", a2 - a1, TRC);
        settle(14);
    endtask

    task automatic t_stream();
        int acc [4];
        for (int b = 0; b < 4; b++)
            send(1'b0, b, 'h200 + b, 'h40 + b, 0, acc[b]);
        settle(16);
        for (int b = 1; b < 4; b++)
            chk("R6 back-to-back spacing", acc[b] - acc[b - 1], 2);
        for (int k = 0; k < 4 * RCLK; k++)
            chk("R6 continuous read data", rdv_log[(acc[0] + 1 + CL + k) % LOGN], 1);
    endtask

    task automatic t_clash();
        int a1, a2;
        // long write then read: read must wait past the write window
        send(1'b1, 0, 'h300, 'h10, 2, a1);
        send(1'b0, 1, 'h301, 'h11, 0, a2);
        settle(14);
        chk("R7 read held behind write", a2 - a1, 3);
        chk("R7 held read lands", rdv_log[(a2 + 1 + CL) % LOGN], 1);
        for (int c = a1; c < a2 + 10; c++)
            chk("R7 no shared clock", rdv_log[c % LOGN] & wen_log[c % LOGN], 0);
        // read then write: write must wait past the read window
        send(1'b0, 2, 'h302, 'h12, 0, a1);
        send(1'b1, 3, 'h303, 'h13, 1, a2);
        settle(14);
        chk("R7 write held behind read", a2 - a1, 3);
        for (int c = a1; c < a2 + 10; c++)
            chk("R7 no shared clock rev", rdv_log[c % LOGN] & wen_log[c % LOGN], 0);
    endtask

    task automatic t_refresh();
        int r, a, c;
        // refresh and read presented together: refresh wins
        req_write = 1'b0;
        req_bank  = 2'd0;
        req_upper = UA_W'('h055);
        req_lower = LA_W'('h05);
        req_wbl   = 2'd0;
        req_valid = 1'b1;
        ref_valid = 1'b1;
        #1;
        chk("R8 refresh ready", int'(ref_ready), 1);
        chk("R8 request held by refresh", int'(req_ready), 0);
        r = cyc + 1;
        @(posedge clk);
        @(negedge clk);
        ref_valid = 1'b0;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        a = cyc + 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        settle(14);
        chk("R8 first refresh cmd", cmd_log[r % LOGN], 2);
        chk("R8 refresh cmd", cmd_log[(r + 1) % LOGN], 4);
        chk("R8 refresh bank", bank_log[(r + 1) % LOGN], 0);
        chk("R8 refresh addr", addr_log[(r + 1) % LOGN], 0);
        chk("R8 all banks busy", busy_log[r % LOGN], (1 << NBANK) - 1);
        chk("R8 recovery spacing", a - r, REFC);
        for (int k = 0; k < 8; k++)
            chk("R8 write cancelled", wen_log[(r + k) % LOGN], 0);
        // refresh raised behind a read waits for bank and bus
        send(1'b0, 3, 'h066, 'h06, 0, a);
        ref_valid = 1'b1;
        #1;
        while (!ref_ready) begin
            @(negedge clk);
            #1;
        end
        r = cyc + 1;
        @(posedge clk);
        @(negedge clk);
        ref_valid = 1'b0;
        settle(12);
        c = (a + TRC - 1 > a + CL + RCLK + 1) ? (a + TRC - 1) : (a + CL + RCLK + 1);
        chk("R8 refresh waits for idle", r, c + 1);
        chk("R8 delayed refresh cmd", cmd_log[(r + 1) % LOGN], 4);
    endtask

    initial begin
        t_reset();
        t_read();
        t_write_codes();
        t_same_bank();
        t_stream();
        t_clash();
        t_refresh();
        summary();
        $finish;
    end
endmodule